// File: doc/BRIEF.md
# Rotating Priority Resolver with End-of-Interrupt Handling

This block sits beside the request and mask registers of one eight-line interrupt controller. It holds the in-service register, a rotation base and a rotate-on-auto-EOI flag. From these it decides each cycle whether an interrupt is presented to the processor and which line that is. The best candidate is the unmasked request that comes first in a circular scan starting at the rotation base. It is raised only when it ranks strictly ahead of every line already in service.

Software drives the block with a command byte whose top three bits select an operation. The operations are non-specific or specific end-of-interrupt, each with an optional rotating form, setting the priority base, arming or disarming rotation on automatic EOI, and a no-op. A processor acknowledge moves the presented line into service. In automatic-EOI mode it instead leaves the in-service register alone and may rotate the base. Every update takes effect on the next clock edge. The interrupt output and line number are combinational.

The design is built around a command decoder with an enumerated command kind and a `unique case`. Its "states" are the eight command kinds: rotate-AEOI clear, non-specific EOI, no-op, specific EOI, rotate-AEOI set, rotating non-specific EOI, set priority, and rotating specific EOI. The only transition is the single-cycle update of in-service, base and flag selected by that kind or by an acknowledge.

Top module: `pic_rot_resolver`

## Requirements
- R1: While `rst_n` is low and after its release, `isr_q` is 0, `rot_base` is 0, `rot_aeoi` is 0, and with no request `irq_out` is 0.
- R2: The presented line is the first line with `req & ~mask` set, scanning `rot_base`, `rot_base+1`, … modulo 8; `irq_line` gives its number.
- R3: Masked lines are never presented. `irq_out` is 1 only if the candidate's scan rank is strictly lower than the rank of the best in-service line; an equal or worse rank gives 0.
- R4: With `sfn_en` and `primary` both 1, the in-service bit of line 2 is left out of the in-service rank. With either at 0, it counts.
- R5: `ack` while `irq_out` is 1 and `auto_eoi_en` is 0 sets `isr_q[irq_line]` on the next edge. `ack` while `irq_out` is 0 changes nothing.
- R6: Command code `cmd_byte[7:5]`=001 clears the in-service bit with the best scan rank. Code 101 does the same and also sets `rot_base` to that line + 1 (mod 8). With `isr_q` empty, neither code changes anything.
- R7: Code 011 clears `isr_q[cmd_byte[2:0]]`. Code 111 does the same and also sets `rot_base` to `cmd_byte[2:0]`+1 (mod 8).
- R8: Code 110 sets `rot_base` to `cmd_byte[2:0]`+1 (mod 8) and leaves `isr_q` unchanged.
- R9: Code 100 sets `rot_aeoi` and code 000 clears it. With `auto_eoi_en`=1, an accepted `ack` leaves `isr_q` unchanged. If `rot_aeoi` is 1, it also sets `rot_base` to `irq_line`+1.
- R10: Code 010 changes no state. When `cmd_valid` and `ack` arrive in the same cycle, the command is carried out and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 8 | Pending request bits |
| mask | input | 8 | Mask bits, 1 blocks a line |
| auto_eoi_en | input | 1 | Automatic-EOI mode |
| sfn_en | input | 1 | Special nested handling of the cascade line |
| primary | input | 1 | This controller is the primary one |
| ack | input | 1 | Processor acknowledge of the presented line |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command: [7:5] code, [2:0] line/value |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_line | output | 3 | Number of the presented line |
| isr_q | output | 8 | In-service register |
| rot_base | output | 3 | Current rotation base |
| rot_aeoi | output | 1 | Rotate-on-auto-EOI flag |

## Verification
A wrong in-service register or rotation base shows up combinationally on `irq_out` and `irq_line` in the cycle right after the faulty edge. A request that should win is then suppressed, or the wrong line is named. Because the bench drives requests chosen so that the expected winner depends on one specific bit of state, each corruption surfaces within one cycle. The in-service register and base are also visible directly, so a missed or misplaced EOI is seen on the edge that caused it.

// File: rtl/pic_prio_pkg.sv
package pic_prio_pkg;
    // Command kinds, selected by the top three bits of the command byte.
    typedef enum logic [2:0] {
        CMD_AEOI_CLR  = 3'b000,
        CMD_NS_EOI    = 3'b001,
        CMD_NOP       = 3'b010,
        CMD_SP_EOI    = 3'b011,
        CMD_AEOI_SET  = 3'b100,
        CMD_ROT_NS    = 3'b101,
        CMD_SET_PRIO  = 3'b110,
        CMD_ROT_SP    = 3'b111
    } cmd_kind_e;
endpackage

// File: rtl/prio_scan.sv
module prio_scan #(
    parameter int N_LINES = 8,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] bits,
    input  logic [LW-1:0]      base,
    output logic [LW:0]        rank
);
    logic [N_LINES-1:0] rotated;

    // rotated[k] is the line found k steps after the base
    for (genvar g = 0; g < N_LINES; g++) begin : g_rot
        logic [LW-1:0] src;
        assign src = LW'(g) + base;
        assign rotated[g] = bits[src];
    end

    always_comb begin
        rank = (LW+1)'(N_LINES);
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (rotated[i]) rank = (LW+1)'(i);
        end
    end
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_prio_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic          valid,
    input  logic [7:0]    cmd_byte,
    output logic          eoi_top,
    output logic          eoi_named,
    output logic          rotate,
    output logic          set_prio,
    output logic          aeoi_wr,
    output logic          aeoi_val,
    output logic [LW-1:0] arg
);
    cmd_kind_e kind;

    assign kind = cmd_kind_e'(cmd_byte[7:5]);
    assign arg  = cmd_byte[LW-1:0];

    always_comb begin
        eoi_top   = 1'b0;
        eoi_named = 1'b0;
        rotate    = 1'b0;
        set_prio  = 1'b0;
        aeoi_wr   = 1'b0;
        aeoi_val  = 1'b0;
        if (valid) begin
            unique case (kind)
                CMD_AEOI_CLR: aeoi_wr = 1'b1;
                CMD_AEOI_SET: begin aeoi_wr = 1'b1; aeoi_val = 1'b1; end
                CMD_NS_EOI:   eoi_top = 1'b1;
                CMD_ROT_NS:   begin eoi_top = 1'b1; rotate = 1'b1; end
                CMD_SP_EOI:   eoi_named = 1'b1;
                CMD_ROT_SP:   begin eoi_named = 1'b1; rotate = 1'b1; end
                CMD_SET_PRIO: set_prio = 1'b1;
                CMD_NOP:      ;
            endcase
        end
    end
endmodule

// File: rtl/pic_rot_resolver.sv
module pic_rot_resolver
    import pic_prio_pkg::*;
#(
    parameter int N_LINES  = 8,
    parameter int CASC_LINE = 2,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req,
    input  logic [N_LINES-1:0] mask,
    input  logic               auto_eoi_en,
    input  logic               sfn_en,
    input  logic               primary,
    input  logic               ack,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_byte,
    output logic               irq_out,
    output logic [LW-1:0]      irq_line,
    output logic [N_LINES-1:0] isr_q,
    output logic [LW-1:0]      rot_base,
    output logic               rot_aeoi
);
    localparam logic [N_LINES-1:0] CASC_BIT = N_LINES'(1) << CASC_LINE;
    localparam logic [LW:0]        NONE     = (LW+1)'(N_LINES);

    logic [N_LINES-1:0] cand, isr_view, isr_d;
    logic [LW:0]        rank_req, rank_svc, rank_top;
    logic [LW-1:0]      top_line, base_d, arg;
    logic               aeoi_d;
    logic               eoi_top, eoi_named, rotate, set_prio, aeoi_wr, aeoi_val;

    assign cand     = req & ~mask;
    assign isr_view = (sfn_en && primary) ? (isr_q & ~CASC_BIT) : isr_q;

    prio_scan #(.N_LINES(N_LINES)) u_scan_req (.bits(cand),     .base(rot_base), .rank(rank_req));
    prio_scan #(.N_LINES(N_LINES)) u_scan_svc (.bits(isr_view), .base(rot_base), .rank(rank_svc));
    prio_scan #(.N_LINES(N_LINES)) u_scan_top (.bits(isr_q),    .base(rot_base), .rank(rank_top));

    pic_cmd_decode #(.N_LINES(N_LINES)) u_dec (
        .valid(cmd_valid), .cmd_byte(cmd_byte),
        .eoi_top(eoi_top), .eoi_named(eoi_named), .rotate(rotate),
        .set_prio(set_prio), .aeoi_wr(aeoi_wr), .aeoi_val(aeoi_val), .arg(arg)
    );

    assign irq_out  = rank_req < rank_svc;
    assign irq_line = rank_req[LW-1:0] + rot_base;
    assign top_line = rank_top[LW-1:0] + rot_base;

    // next-state selection: a command takes precedence over an acknowledge
    always_comb begin
        isr_d  = isr_q;
        base_d = rot_base;
        aeoi_d = rot_aeoi;
        if (cmd_valid) begin
            if (aeoi_wr) aeoi_d = aeoi_val;
            if (eoi_top && rank_top != NONE) begin
                isr_d[top_line] = 1'b0;
                if (rotate) base_d = top_line + LW'(1);
            end
            if (eoi_named) begin
                isr_d[arg] = 1'b0;
                if (rotate) base_d = arg + LW'(1);
            end
            if (set_prio) base_d = arg + LW'(1);
        end else if (ack && irq_out) begin
            if (auto_eoi_en) begin
                if (rot_aeoi) base_d = irq_line + LW'(1);
            end else begin
                isr_d[irq_line] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q    <= '0;
            rot_base <= '0;
            rot_aeoi <= 1'b0;
        end else begin
            isr_q    <= isr_d;
            rot_base <= base_d;
            rot_aeoi <= aeoi_d;
        end
    end

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:5] == 3'b010) |=> ($stable(isr_q) && $stable(rot_base) && $stable(rot_aeoi))); // R10
    AST_SETPRIO_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:5] == 3'b110) |=> $stable(isr_q)); // R8
    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !auto_eoi_en && !cmd_valid) |=> isr_q[$past(irq_line)]); // R5
    AST_AEOI_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi_en && !cmd_valid) |=> $stable(isr_q)); // R9
    AST_SPEOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[6:5] == 2'b11) |=> !isr_q[$past(cmd_byte[LW-1:0])]); // R7
    AST_MASKED_NEVER_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> !mask[irq_line]); // R3
endmodule

// File: tb/test_pic_rot_resolver.sv
module test_pic_rot_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, mask = '0, cmd_byte = '0;
    logic       auto_eoi_en = 1'b0, sfn_en = 1'b0, primary = 1'b1;
    logic       ack = 1'b0, cmd_valid = 1'b0;
    logic       irq_out, rot_aeoi;
    logic [2:0] irq_line, rot_base;
    logic [7:0] isr_q;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pic_rot_resolver i_pic_rot_resolver (
        .clk(clk), .rst_n(rst_n), .req(req), .mask(mask),
        .auto_eoi_en(auto_eoi_en), .sfn_en(sfn_en), .primary(primary),
        .ack(ack), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .irq_out(irq_out), .irq_line(irq_line), .isr_q(isr_q),
        .rot_base(rot_base), .rot_aeoi(rot_aeoi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic command(input logic [2:0] code, input logic [2:0] val);
        cmd_valid = 1'b1;
        cmd_byte  = {code, 2'b00, val};
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 isr", isr_q, 8'h00);
        chk("R1 base", rot_base, 0);
        chk("R1 aeoi flag", rot_aeoi, 0);
        chk("R1 irq idle", irq_out, 0);
    endtask

    task automatic t_scan();
        req = 8'h28; #1;
        chk("R2 lowest from base 0", {irq_out, irq_line}, {1'b1, 3'd3});
        mask = 8'h08; #1;
        chk("R3 masked line skipped", {irq_out, irq_line}, {1'b1, 3'd5});
        mask = 8'h28; #1;
        chk("R3 all masked", irq_out, 0);
        mask = 8'h00;
        command(3'b110, 3'd3);
        chk("R8 base set", rot_base, 3'd4);
        chk("R8 isr kept", isr_q, 8'h00);
        chk("R2 scan from base 4", {irq_out, irq_line}, {1'b1, 3'd5});
        req = 8'h08; #1;
        chk("R2 wrap around", {irq_out, irq_line}, {1'b1, 3'd3});
        command(3'b110, 3'd7);
        chk("R8 base wraps to 0", rot_base, 3'd0);
    endtask

    task automatic t_ack();
        req = 8'h20; #1;
        do_ack();
        chk("R5 ack sets isr", isr_q, 8'h20);
        chk("R3 equal rank blocked", irq_out, 0);
        req = 8'h04; #1;
        chk("R3 better rank raised", {irq_out, irq_line}, {1'b1, 3'd2});
        req = 8'h40; #1;
        chk("R3 worse rank blocked", irq_out, 0);
        do_ack();
        chk("R5 ack ignored when idle", isr_q, 8'h20);
    endtask

    task automatic t_nested();
        req = 8'h04; #1;
        do_ack();
        chk("R5 second in service", isr_q, 8'h24);
        req = 8'h08; #1;
        chk("R4 cascade counts when off", irq_out, 0);
        sfn_en = 1'b1; #1;
        chk("R4 cascade ignored", {irq_out, irq_line}, {1'b1, 3'd3});
        primary = 1'b0; #1;
        chk("R4 secondary keeps cascade", irq_out, 0);
        sfn_en = 1'b0; primary = 1'b1;
    endtask

    task automatic t_ns_eoi();
        req = 8'h00;
        command(3'b001, 3'd0);
        chk("R6 ns eoi clears best", isr_q, 8'h20);
        chk("R6 ns eoi keeps base", rot_base, 3'd0);
        command(3'b101, 3'd0);
        chk("R6 rot ns eoi clears", isr_q, 8'h00);
        chk("R6 rot ns eoi base", rot_base, 3'd6);
        command(3'b101, 3'd0);
        chk("R6 empty isr no change", {isr_q, rot_base}, {8'h00, 3'd6});
    endtask

    task automatic t_sp_eoi();
        command(3'b110, 3'd7);
        req = 8'h10; #1;
        do_ack();
        req = 8'h02; #1;
        do_ack();
        chk("R5 two in service", isr_q, 8'h12);
        req = 8'h00;
        command(3'b011, 3'd4);
        chk("R7 specific clears named", {isr_q, rot_base}, {8'h02, 3'd0});
        command(3'b111, 3'd1);
        chk("R7 rot specific", {isr_q, rot_base}, {8'h00, 3'd2});
    endtask

    task automatic t_aeoi();
        auto_eoi_en = 1'b1;
        command(3'b100, 3'd0);
        chk("R9 flag set", rot_aeoi, 1);
        req = 8'h40; #1;
        do_ack();
        chk("R9 aeoi rotate", {isr_q, rot_base}, {8'h00, 3'd7});
        command(3'b000, 3'd0);
        chk("R9 flag cleared", rot_aeoi, 0);
        req = 8'h08; #1;
        do_ack();
        chk("R9 aeoi no rotate", {isr_q, rot_base}, {8'h00, 3'd7});
        auto_eoi_en = 1'b0;
    endtask

    task automatic t_nop();
        do_ack();
        chk("R5 line 3 in service", isr_q, 8'h08);
        command(3'b010, 3'd5);
        chk("R10 nop holds", {isr_q, rot_base, rot_aeoi}, {8'h08, 3'd7, 1'b0});
        req = 8'h02; #1;
        chk("R2 line 1 from base 7", {irq_out, irq_line}, {1'b1, 3'd1});
        ack = 1'b1;
        command(3'b010, 3'd0);
        ack = 1'b0;
        chk("R10 ack dropped under command", isr_q, 8'h08);
        do_ack();
        chk("R5 ack after command", isr_q, 8'h0A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_scan();
        t_ack();
        t_nested();
        t_ns_eoi();
        t_sp_eoi();
        t_aeoi();
        t_nop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule